// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sets how long each bus access lasts. For every access it takes a region code (the upper address byte), the access width, whether the access is sequential, whether it is an instruction fetch, and an optional burst length. From these and a 16-bit timing control word it computes a wait count, holds the access for that many cycles and then raises a ready signal. Internal regions have fixed timings. Three external ROM windows and one SRAM window take their timings from fields of the control word.

A 32-bit access to a 16-bit ROM window runs as two halves. The first half is nonsequential and the second is sequential, so it costs the nonsequential wait, plus one, plus the sequential wait. A burst request covers a transfer of several words. Its cost is one nonsequential 32-bit transfer followed by sequential 32-bit transfers, each transfer counting one bus cycle plus its waits.

Control is a two-state machine. `ST_IDLE` waits for a start strobe. The transition IDLE->IDLE is taken for a zero-cost access, and ready is raised in the start cycle itself. The transition IDLE->WAIT is taken for a nonzero cost, and the remaining count is loaded. `ST_WAIT` counts down. It stays in WAIT->WAIT while the count is nonzero and takes WAIT->IDLE in the cycle where ready is high.

Top module: `wait_state_gen`

## Requirements
- R1: After reset the control word is 0 and the block is idle: `busy_o` and `ready_o` are low while `start_i` is low.
- R2: An access with a computed wait of 0 raises `ready_o` in the same cycle as `start_i`, with `busy_o` low. Region codes 0x00, 0x01 and 0x03 to 0x07 cost 0. So does any region byte with a nonzero upper nibble.
- R3: An access with wait W>0 started in cycle 0 raises `ready_o` in cycle W only. `busy_o` is high in cycles 1 to W. `start_i` is ignored while `busy_o` is high.
- R4: Region 0x02 (on-board work RAM) costs 2 for 8/16-bit accesses and 5 for 32-bit accesses, whatever the sequential flag.
- R5: The 2-bit first-access code maps 0,1,2,3 to 4,3,2,8 waits. The code sits in control bits [3:2] for window 0 (regions 0x08/0x09), in bits [6:5] for window 1 (0x0A/0x0B) and in bits [9:8] for window 2 (0x0C/0x0D). A nonsequential 8/16-bit ROM access uses this value.
- R6: A sequential 8/16-bit ROM access uses the sequential bit of its window: bit 4 for window 0, bit 7 for window 1, bit 10 for window 2. A clear bit gives 2, 4 or 8 waits for windows 0, 1 and 2. A set bit gives 1.
- R7: A 32-bit ROM access costs first+1+seq when nonsequential and 2*seq+1 when sequential, where first and seq are that window's 16-bit values.
- R8: The SRAM window (regions 0x0E/0x0F) uses the code in control bits [1:0], mapped as in R5. An 8/16-bit access costs that value w. A 32-bit access costs 2*w+1, sequential or not.
- R9: The two region codes of each ROM window, and of the SRAM window, always give the same timing.
- R10: When control bit 14 is set, a non-burst instruction fetch (`fetch_i`=1) to a ROM window costs 0. Data accesses, the SRAM window and work RAM keep their normal waits.
- R11: With `burst_i`=1 and N=`burst_len_i` (0 treated as 1), the cost is (1+N32)+(N-1)*(1+S32). N32 and S32 are the region's nonsequential and sequential 32-bit waits. The sequential, width and fetch inputs are ignored.
- R12: A control word written with `cfg_we_i` applies from the access after that cycle. An access started in the same cycle, or already in progress, keeps the count it loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the timing control word |
| cfg_data_i | input | 16 | New timing control word |
| start_i | input | 1 | Access start strobe, taken only while idle |
| region_i | input | REGION_W (8) | Region code (upper address byte) |
| wide_i | input | 1 | 1 = 32-bit access, 0 = 8/16-bit access |
| seq_i | input | 1 | 1 = sequential access |
| fetch_i | input | 1 | 1 = instruction fetch |
| burst_i | input | 1 | 1 = multi-word burst transfer |
| burst_len_i | input | LEN_W (4) | Burst word count, 0 read as 1 |
| ready_o | output | 1 | Access complete |
| busy_o | output | 1 | An access is being stretched |

## Verification
The `ready_o` output for a zero-cost access is combinational, so it is due in the start cycle itself. For a cost of W it is due exactly W clock edges after the edge that captured `start_i`. The bench drives every input just after a falling edge and reads `ready_o` and `busy_o` shortly afterwards. It counts the rising edges since the start cycle, so the measured value is the wait count itself and can be compared directly with the value worked out from the requirements. A new control word is visible from the first edge after its write cycle. The bench therefore places writes relative to start strobes, in the same cycle and in mid-access, to check which count each access loads.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wsg_state_e;

    // Widest single wait is 8 + 1 + 8 = 17.
    localparam int unsigned WAIT_W      = 5;
    localparam int unsigned NUM_ROM_WIN = 3;
    localparam int unsigned ROM_BASE    = 8;   // first ROM window region code
    localparam int unsigned SRAM_BASE   = 14;  // SRAM window region code pair
    localparam int unsigned WRAM_CODE   = 2;   // on-board work RAM
    localparam int unsigned WRAM_W16    = 2;
    localparam int unsigned WRAM_W32    = 5;
    localparam int unsigned PF_BIT      = 14;  // prefetch enable bit

    typedef struct packed {
        logic [WAIT_W-1:0] n16;
        logic [WAIT_W-1:0] s16;
        logic [WAIT_W-1:0] n32;
        logic [WAIT_W-1:0] s32;
    } wsg_timing_t;

    // 2-bit first-access / SRAM code to wait cycles.
    function automatic logic [WAIT_W-1:0] first_wait(input logic [1:0] code);
        logic [WAIT_W-1:0] w;
        unique case (code)
            2'd0:    w = WAIT_W'(4);
            2'd1:    w = WAIT_W'(3);
            2'd2:    w = WAIT_W'(2);
            default: w = WAIT_W'(8);
        endcase
        return w;
    endfunction

    // Sequential bit of window 'win': clear gives 2 << win, set gives 1.
    function automatic logic [WAIT_W-1:0] seq_wait(input int unsigned win, input logic fast);
        return fast ? WAIT_W'(1) : WAIT_W'(2 << win);
    endfunction

endpackage

// File: rtl/wsg_cfg_reg.sv
module wsg_cfg_reg #(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/wsg_timing_decode.sv
module wsg_timing_decode
    import wsg_pkg::*;
#(
    parameter int unsigned REGION_W = 8,
    parameter int unsigned LEN_W    = 4,
    parameter int unsigned CNT_W    = 9
) (
    input  logic [15:0]         cfg,
    input  logic [REGION_W-1:0] region,
    input  logic                wide,
    input  logic                seq,
    input  logic                fetch,
    input  logic                burst,
    input  logic [LEN_W-1:0]    len,
    output logic [CNT_W-1:0]    wait_cnt
);

    wsg_timing_t win_t [NUM_ROM_WIN];
    wsg_timing_t sram_t;
    wsg_timing_t sel;
    logic        is_rom;
    logic        hi_nz;
    logic [3:0]  code;
    logic [CNT_W-1:0] single_c;
    logic [CNT_W-1:0] burst_c;
    logic [CNT_W-1:0] n_m1;
    logic        unused_cfg;

    assign unused_cfg = ^{cfg[15], cfg[13:11]};

    // One timing set per ROM window, fields at a stride of 3 bits.
    for (genvar g = 0; g < NUM_ROM_WIN; g++) begin : g_win
        logic [WAIT_W-1:0] f16;
        logic [WAIT_W-1:0] q16;
        assign f16 = first_wait(cfg[2 + 3*g +: 2]);
        assign q16 = seq_wait(g, cfg[4 + 3*g]);
        assign win_t[g] = '{n16: f16,
                            s16: q16,
                            n32: f16 + WAIT_W'(1) + q16,
                            s32: {q16[WAIT_W-2:0], 1'b1}};
    end

    logic [WAIT_W-1:0] sram_w;
    assign sram_w = first_wait(cfg[1:0]);
    assign sram_t = '{n16: sram_w, s16: sram_w,
                      n32: {sram_w[WAIT_W-2:0], 1'b1},
                      s32: {sram_w[WAIT_W-2:0], 1'b1}};

    assign code  = region[3:0];
    assign hi_nz = |region[REGION_W-1:4];

    always_comb begin
        sel    = '0;
        is_rom = 1'b0;
        if (!hi_nz) begin
            if (code == 4'(WRAM_CODE)) begin
                sel = '{n16: WAIT_W'(WRAM_W16), s16: WAIT_W'(WRAM_W16),
                        n32: WAIT_W'(WRAM_W32), s32: WAIT_W'(WRAM_W32)};
            end
            for (int w = 0; w < NUM_ROM_WIN; w++) begin
                if (code[3:1] == 3'(ROM_BASE/2 + w)) begin
                    sel    = win_t[w];
                    is_rom = 1'b1;
                end
            end
            if (code[3:1] == 3'(SRAM_BASE/2)) begin
                sel = sram_t;
            end
        end
    end

    always_comb begin
        if (cfg[PF_BIT] && fetch && is_rom) begin
            single_c = '0;
        end else if (wide) begin
            single_c = CNT_W'(seq ? sel.s32 : sel.n32);
        end else begin
            single_c = CNT_W'(seq ? sel.s16 : sel.n16);
        end
    end

    assign n_m1    = (len == '0) ? '0 : CNT_W'(len) - CNT_W'(1);
    assign burst_c = CNT_W'(1) + CNT_W'(sel.n32)
                   + n_m1 * (CNT_W'(1) + CNT_W'(sel.s32));

    assign wait_cnt = burst ? burst_c : single_c;

endmodule

// File: rtl/wsg_wait_fsm.sv
module wsg_wait_fsm
    import wsg_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] wait_cnt,
    output logic             ready,
    output logic             busy
);

    wsg_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (wait_cnt != '0)) begin
                    state_d  = ST_WAIT;
                    remain_d = wait_cnt - CNT_W'(1);
                end
            end
            ST_WAIT: begin
                if (remain_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    remain_d = remain_q - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = start && (wait_cnt == '0);
            ST_WAIT: begin
                busy  = 1'b1;
                ready = (remain_q == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
    parameter int unsigned REGION_W = 8,
    parameter int unsigned LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we_i,
    input  logic [15:0]         cfg_data_i,
    input  logic                start_i,
    input  logic [REGION_W-1:0] region_i,
    input  logic                wide_i,
    input  logic                seq_i,
    input  logic                fetch_i,
    input  logic                burst_i,
    input  logic [LEN_W-1:0]    burst_len_i,
    output logic                ready_o,
    output logic                busy_o
);

    // Largest step is 1 + 17; at most 2^LEN_W - 1 words.
    localparam int unsigned MAX_COST = 18 * ((1 << LEN_W) - 1);
    localparam int unsigned CNT_W    = $clog2(MAX_COST + 1);

    logic [15:0]      cfg_q;
    logic [CNT_W-1:0] wait_cnt;

    wsg_cfg_reg #(.CFG_W(16)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we_i),
        .wdata (cfg_data_i),
        .cfg_q (cfg_q)
    );

    wsg_timing_decode #(
        .REGION_W (REGION_W),
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W)
    ) u_dec (
        .cfg      (cfg_q),
        .region   (region_i),
        .wide     (wide_i),
        .seq      (seq_i),
        .fetch    (fetch_i),
        .burst    (burst_i),
        .len      (burst_len_i),
        .wait_cnt (wait_cnt)
    );

    wsg_wait_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .wait_cnt (wait_cnt),
        .ready    (ready_o),
        .busy     (busy_o)
    );

endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int unsigned REGION_W = 8,
    parameter int unsigned CNT_W    = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                fetch_i,
    input logic                burst_i,
    input logic [REGION_W-1:0] region_i,
    input logic                ready_o,
    input logic                busy_o,
    input logic [15:0]         cfg_q,
    input logic [CNT_W-1:0]    wait_cnt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] exp_q;
    logic             rom_fetch;

    // Independent elapsed-cycle counter since the accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else if (start_i && !busy_o) begin
            cnt_q <= CNT_W'(1);
            exp_q <= wait_cnt;
        end else if (busy_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign rom_fetch = fetch_i && !burst_i && cfg_q[14]
                     && (region_i[REGION_W-1:4] == '0)
                     && (region_i[3:0] >= 4'h8) && (region_i[3:0] <= 4'hD);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy_o);

    assert_idle_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !busy_o) |-> start_i);

    assert_exact_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ready_o == (cnt_q == exp_q)));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ready_o) |=> !busy_o);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ready_o) |=> busy_o);

    assert_prefetch_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rom_fetch) |-> ready_o);

endmodule

bind wait_state_gen wsg_checker #(
    .REGION_W (REGION_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fetch_i  (fetch_i),
    .burst_i  (burst_i),
    .region_i (region_i),
    .ready_o  (ready_o),
    .busy_o   (busy_o),
    .cfg_q    (cfg_q),
    .wait_cnt (wait_cnt)
);

// File: tb/wait_state_gen_test.sv
module wait_state_gen_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [15:0] cfg_data_i = '0;
    logic       start_i = 1'b0;
    logic [7:0] region_i = '0;
    logic       wide_i = 1'b0, seq_i = 1'b0, fetch_i = 1'b0, burst_i = 1'b0;
    logic [3:0] burst_len_i = '0;
    logic       ready_o, busy_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_state_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
        .start_i(start_i), .region_i(region_i), .wide_i(wide_i), .seq_i(seq_i),
        .fetch_i(fetch_i), .burst_i(burst_i), .burst_len_i(burst_len_i),
        .ready_o(ready_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [15:0] cfg;
        logic [7:0]  region;
        logic        wide;
        logic        seq;
        logic        fetch;
        logic        burst;
        logic [3:0]  len;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        // R5 first-access map, R6 sequential bits, R7 32-bit ROM
        '{16'h0000, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd4,  8'd5},
        '{16'h0000, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd2,  8'd6},
        '{16'h0000, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd4,  8'd6},
        '{16'h0000, 8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd8,  8'd6},
        '{16'h0000, 8'h0D, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd13, 8'd7},
        '{16'h0000, 8'h0D, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd17, 8'd7},
        '{16'h001C, 8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd8,  8'd5},
        '{16'h001C, 8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd10, 8'd7},
        '{16'h0010, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd1,  8'd6},
        '{16'h0040, 8'h0B, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd2,  8'd5},
        '{16'h0080, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd1,  8'd6},
        '{16'h0100, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd3,  8'd5},
        '{16'h0400, 8'h0D, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd3,  8'd7},
        // R8 SRAM window, R9 adjacent codes
        '{16'h0003, 8'h0E, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd8,  8'd8},
        '{16'h0003, 8'h0E, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd17, 8'd8},
        '{16'h0003, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd17, 8'd9},
        '{16'h0001, 8'h0E, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd3,  8'd8},
        '{16'h0000, 8'h09, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd5,  8'd9},
        // R4 work RAM, R2 zero-wait regions
        '{16'h0000, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd2,  8'd4},
        '{16'h0000, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd5,  8'd4},
        '{16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd0,  8'd2},
        '{16'h0000, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd0,  8'd2},
        '{16'h0000, 8'h28, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd0,  8'd2},
        // R10 prefetch
        '{16'h4000, 8'h08, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 16'd0,  8'd10},
        '{16'h4000, 8'h0C, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 16'd0,  8'd10},
        '{16'h4000, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd4,  8'd10},
        '{16'h4000, 8'h0E, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd4,  8'd10},
        '{16'h4000, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd2,  8'd10},
        '{16'h0000, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd4,  8'd10},
        // R11 burst cost
        '{16'h0000, 8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 16'd20, 8'd11},
        '{16'h0000, 8'h08, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 16'd8,  8'd11},
        '{16'h0000, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 16'd24, 8'd11},
        '{16'h0000, 8'h03, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 16'd2,  8'd11},
        '{16'h4000, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 16'd14, 8'd11},
        '{16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 16'd1,  8'd11},
        '{16'h0000, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 16'd150, 8'd11}
    };

    task automatic check(input string req, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we_i   = 1'b1;
        cfg_data_i = v;
        @(negedge clk);
        cfg_we_i   = 1'b0;
    endtask

    // Start an access; returns edges from start to ready and count of
    // cycles in the window where busy_o was low.
    task automatic measure(input logic [7:0] rg, input logic wd, input logic sq,
                           input logic fe, input logic bu, input logic [3:0] ln,
                           output int got, output int busy_low);
        @(negedge clk);
        region_i = rg; wide_i = wd; seq_i = sq; fetch_i = fe; burst_i = bu;
        burst_len_i = ln; start_i = 1'b1;
        busy_low = 0;
        #1;
        if (ready_o) begin
            got = 0;
            @(negedge clk);
            start_i = 1'b0;
        end else begin
            got = -1;
            for (int k = 1; k <= 400 && got < 0; k++) begin
                @(negedge clk);
                start_i = 1'b0;
                #1;
                if (!busy_o) busy_low++;
                if (ready_o) got = k;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int got, bl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk); #1;
        check("R1", ready_o, 0, "ready after reset");
        check("R1", busy_o, 0, "busy after reset");
        // R1: control word resets to 0 -> window 0 first access is 4
        measure(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, got, bl);
        check("R1", got, 4, "default window0 wait");

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].cfg);
            measure(VECS[i].region, VECS[i].wide, VECS[i].seq, VECS[i].fetch,
                    VECS[i].burst, VECS[i].len, got, bl);
            check($sformatf("R%0d", VECS[i].req), got, int'(VECS[i].exp),
                  $sformatf("vector %0d wait", i));
            check("R3", bl, 0, $sformatf("vector %0d busy gaps", i));
        end

        // R3: start ignored while busy
        write_cfg(16'h0000);
        @(negedge clk);
        region_i = 8'h0C; wide_i = 1'b1; seq_i = 1'b1; fetch_i = 1'b0; burst_i = 1'b0;
        start_i = 1'b1;                  // cost 17
        @(negedge clk); start_i = 1'b0;  // cycle 1
        @(negedge clk);                  // cycle 2: re-strobe a zero-cost access
        region_i = 8'h00; start_i = 1'b1; #1;
        check("R3", ready_o, 0, "zero-cost start while busy");
        check("R3", busy_o, 1, "busy during access");
        begin
            int seen;
            seen = -1;
            for (int k = 3; k <= 40 && seen < 0; k++) begin
                @(negedge clk); start_i = 1'b0; #1;
                if (ready_o) seen = k;
            end
            check("R3", seen, 17, "ready cycle unchanged by ignored start");
        end
        @(negedge clk); #1;
        check("R3", busy_o, 0, "idle after ready");

        // R12: write during an access does not alter it
        write_cfg(16'h0000);
        @(negedge clk);
        region_i = 8'h08; wide_i = 1'b0; seq_i = 1'b0; start_i = 1'b1;  // 4
        @(negedge clk); start_i = 1'b0; cfg_we_i = 1'b1; cfg_data_i = 16'h000C;
        @(negedge clk); cfg_we_i = 1'b0;
        begin
            int seen;
            seen = -1;
            #1; if (ready_o) seen = 2;
            for (int k = 3; k <= 20 && seen < 0; k++) begin
                @(negedge clk); #1;
                if (ready_o) seen = k;
            end
            check("R12", seen, 4, "in-flight access keeps its count");
        end
        measure(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, got, bl);
        check("R12", got, 8, "next access uses new word");

        // R12: write in the same cycle as start uses the old word
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_data_i = 16'h0000;
        region_i = 8'h08; start_i = 1'b1;
        begin
            int seen;
            seen = -1;
            #1; if (ready_o) seen = 0;
            for (int k = 1; k <= 20 && seen < 0; k++) begin
                @(negedge clk); start_i = 1'b0; cfg_we_i = 1'b0; #1;
                if (ready_o) seen = k;
            end
            check("R12", seen, 8, "same-cycle write not applied");
        end
        @(negedge clk);
        measure(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, got, bl);
        check("R12", got, 4, "write applied to following access");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule